// File: doc/BRIEF.md
# Two-Mode Cartridge Bank Controller

This block sits on the bus of an 8-bit processor: 16-bit address, 8-bit data, and separate read and write strobes. It turns that bus into accesses to an external program ROM and a battery-backed work RAM. The processor cannot write to the ROM windows, so writes that land there are taken as control writes instead. They set a RAM enable, a 5-bit low ROM bank field, a 2-bit shared field and a mode bit. From these four values the block forms the physical ROM address, the physical RAM address, the chip selects and the RAM write strobe, and it steers the read data back to the processor.

The mode bit decides what the 2-bit shared field does. In ROM mode the field supplies the upper two bits of a 7-bit ROM bank number. In RAM mode it selects the RAM bank, and the ROM bank loses its upper bits. A low bank field of zero is never stored; it is replaced by one. The ROM bank count and the RAM bank count are parameters. A bank number at or past the configured count gives no chip select, and the processor reads zero.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, the ROM bank is 1, the shared field is 0, the mode is ROM mode and the RAM is disabled. A read of 0x4000 therefore maps to physical ROM address 0x04000, and a read of 0xA000 asserts no chip select and returns 0.
- R2: A write to 0x0000–0x1FFF enables the RAM when the data byte is exactly 0x0A and disables it for any other byte.
- R3: A write to 0x2000–0x3FFF loads data bits 4:0 into the low ROM bank field. The shared field is not changed.
- R4: A low bank value of zero is stored as one, so effective banks 0x00, 0x20, 0x40 and 0x60 become 0x01, 0x21, 0x41 and 0x61.
- R5: A write to 0x4000–0x5FFF loads data bits 1:0 into the shared field. In ROM mode this field is ROM bank bits 6:5. In RAM mode it is the RAM bank number.
- R6: A write to 0x6000–0x7FFF sets the mode from data bit 0 (1 = RAM mode). In RAM mode, ROM bank bits 6:5 read as zero. In ROM mode, the RAM bank is 0 and the shared field returns to ROM bank bits 6:5. Writing the mode the block is already in changes nothing.
- R7: A read of 0x0000–0x3FFF always asserts the ROM select with physical address equal to the CPU address (bank 0).
- R8: A read of 0x4000–0x7FFF uses physical ROM address bank × 0x4000 plus the CPU address minus 0x4000, and returns the ROM byte.
- R9: An access to 0xA000–0xBFFF, while the RAM is enabled and the bank is valid, asserts the RAM select at address RAM bank × 0x2000 plus the CPU address minus 0xA000. A write there also asserts the RAM write strobe. While the RAM is disabled, a write stores nothing and a read returns 0.
- R10: A ROM bank at or above ROM_BANKS, or a RAM bank at or above RAM_BANKS, gives no chip select, no write strobe and read data 0.
- R11: An access to 0x8000–0x9FFF or 0xC000–0xFFFF asserts no select and returns 0. A write there changes no control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rdata | output | 8 | Read data to the processor, 0 when nothing is selected |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select |
| rom_rdata | input | 8 | ROM data |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM data |

## Verification
The properties assume the processor never raises its read and write strobes in the same cycle. They also assume the address and data are steady from one falling edge to the next, so every write is captured at exactly one rising edge. The bench drives one access per cycle on the falling edge and drops the write strobe after one edge. It compares the combinational read results in the same half cycle, so both assumptions always hold. The sweep walks every low bank value under every shared-field value. It then changes mode in both directions and repeats a mode write that leaves the mode as it is.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int LO_W      = 5;
  localparam int HI_W      = 2;
  localparam int BANK_W    = LO_W + HI_W;
  localparam int ROM_OFF_W = 14;
  localparam int RAM_OFF_W = 13;
  localparam int ROM_AW    = BANK_W + ROM_OFF_W;
  localparam int RAM_AW    = HI_W + RAM_OFF_W;
  localparam logic [7:0] EN_KEY = 8'h0A;

  typedef enum logic [2:0] {
    W_ENABLE, W_LOBANK, W_FIELD, W_MODE, W_NONE
  } wr_sel_e;

  typedef struct packed {
    logic            ram_en;
    logic            ram_mode;
    logic [HI_W-1:0] field;
    logic [LO_W-1:0] lo;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{ram_en: 1'b0, ram_mode: 1'b0,
                                 field: '0, lo: LO_W'(1)};

  // control register picked by the top three address bits of a write
  function automatic wr_sel_e decode_wr(logic [2:0] top3);
    case (top3)
      3'd0:    return W_ENABLE;
      3'd1:    return W_LOBANK;
      3'd2:    return W_FIELD;
      3'd3:    return W_MODE;
      default: return W_NONE;
    endcase
  endfunction

  // a zero low field is stored as one
  function automatic logic [LO_W-1:0] fix_low(logic [7:0] d);
    if (d[LO_W-1:0] == '0) return LO_W'(1);
    return d[LO_W-1:0];
  endfunction

  function automatic logic [BANK_W-1:0] rom_bank_of(ctrl_t c);
    logic [HI_W-1:0] up;
    up = c.ram_mode ? '0 : c.field;
    return {up, c.lo};
  endfunction

  function automatic logic [HI_W-1:0] ram_bank_of(ctrl_t c);
    return c.ram_mode ? c.field : '0;
  endfunction

  function automatic logic [ROM_AW-1:0] rom_phys(logic [BANK_W-1:0] b,
                                                 logic [ROM_OFF_W-1:0] off);
    return {b, off};
  endfunction

  function automatic logic [RAM_AW-1:0] ram_phys(logic [HI_W-1:0] b,
                                                 logic [RAM_OFF_W-1:0] off);
    return {b, off};
  endfunction

  function automatic logic bank_ok(logic [7:0] b, int unsigned count);
    return 32'(b) < count;
  endfunction
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_sel_e sel,
  input  logic [7:0] wdata,
  output ctrl_t   ctrl_q
);
  ctrl_t ctrl_d;
  logic  en_upd, lo_upd, field_upd, mode_upd;

  assign en_upd    = (sel == W_ENABLE);
  assign lo_upd    = (sel == W_LOBANK);
  assign field_upd = (sel == W_FIELD);
  assign mode_upd  = (sel == W_MODE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (en_upd)    ctrl_d.ram_en   = (wdata == EN_KEY);
    if (lo_upd)    ctrl_d.lo       = fix_low(wdata);
    if (field_upd) ctrl_d.field    = wdata[HI_W-1:0];
    if (mode_upd)  ctrl_d.ram_mode = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 40
) (
  input  logic              rd,
  input  logic [15:0]       addr,
  input  logic [BANK_W-1:0] bank,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic              bank_valid
);
  logic in_fixed, in_switch;
  logic [BANK_W-1:0] sel_bank;

  assign in_fixed   = (addr[15:14] == 2'b00);
  assign in_switch  = (addr[15:14] == 2'b01);
  assign sel_bank   = in_switch ? bank : '0;
  assign bank_valid = bank_ok(8'(sel_bank), ROM_BANKS);
  assign rom_addr   = rom_phys(sel_bank, addr[ROM_OFF_W-1:0]);
  assign rom_cs     = rd && (in_fixed || (in_switch && bank_valid));
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
  import cbc_pkg::*;
#(
  parameter int RAM_BANKS = 3
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [15:0]       addr,
  input  logic              ram_en,
  input  logic [HI_W-1:0]   bank,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              bank_valid
);
  logic in_win;

  assign in_win   = (addr[15:13] == 3'b101);
  assign ram_addr = ram_phys(bank, addr[RAM_OFF_W-1:0]);

  generate
    if (RAM_BANKS == 0) begin : g_no_ram
      assign bank_valid = 1'b0;
    end else begin : g_ram
      assign bank_valid = bank_ok(8'(bank), RAM_BANKS);
    end
  endgenerate

  assign ram_cs = (rd || wr) && in_win && ram_en && bank_valid;
  assign ram_we = ram_cs && wr;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 40,
  parameter int RAM_BANKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  input  logic [7:0]        rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_cs,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata
);
  wr_sel_e           wr_sel;
  ctrl_t             ctrl_q;
  logic [BANK_W-1:0] rom_bank_w;
  logic [HI_W-1:0]   ram_bank_w;
  logic              rom_ok, ram_ok;

  // named state for the bound checker
  logic              en_state, mode_state;
  logic [LO_W-1:0]   lo_state;
  logic [HI_W-1:0]   field_state;

  assign wr_sel = cpu_wr ? decode_wr(cpu_addr[15:13]) : W_NONE;

  cbc_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (wr_sel),
    .wdata  (cpu_wdata),
    .ctrl_q (ctrl_q)
  );

  assign rom_bank_w  = rom_bank_of(ctrl_q);
  assign ram_bank_w  = ram_bank_of(ctrl_q);
  assign en_state    = ctrl_q.ram_en;
  assign mode_state  = ctrl_q.ram_mode;
  assign lo_state    = ctrl_q.lo;
  assign field_state = ctrl_q.field;

  cbc_rom_map #(.ROM_BANKS(ROM_BANKS)) u_rom (
    .rd         (cpu_rd),
    .addr       (cpu_addr),
    .bank       (rom_bank_w),
    .rom_addr   (rom_addr),
    .rom_cs     (rom_cs),
    .bank_valid (rom_ok)
  );

  cbc_ram_map #(.RAM_BANKS(RAM_BANKS)) u_ram (
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .addr       (cpu_addr),
    .ram_en     (en_state),
    .bank       (ram_bank_w),
    .ram_addr   (ram_addr),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .bank_valid (ram_ok)
  );

  assign ram_wdata = cpu_wdata;

  always_comb begin
    if (rom_cs)                 cpu_rdata = rom_rdata;
    else if (ram_cs && cpu_rd)  cpu_rdata = ram_rdata;
    else                        cpu_rdata = 8'h00;
  end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        cpu_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              ram_we,
  input logic              en_state,
  input logic              mode_state,
  input logic [LO_W-1:0]   lo_state,
  input logic [HI_W-1:0]   field_state
);
  p_en_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'd0 |=> en_state == ($past(cpu_wdata) == 8'h0A));

  p_lo_keeps_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'd1 |=> field_state == $past(field_state));

  p_zero_remap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'd1 && cpu_wdata[4:0] == 5'd0 |=> lo_state == 5'd1);

  p_field_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'd2 |=> field_state == $past(cpu_wdata[1:0]));

  p_ram_mode_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_state && rom_cs && cpu_addr[15:14] == 2'b01 |-> rom_addr[ROM_AW-1 -: HI_W] == '0);

  p_fixed_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr[15:14] == 2'b00 |-> rom_cs && rom_addr == ROM_AW'(cpu_addr[13:0]));

  p_ram_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> en_state);

  p_we_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs && cpu_wr);

  p_rom_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> 32'(rom_addr[ROM_AW-1:ROM_OFF_W]) < ROM_BANKS);

  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr[15] && cpu_addr[15:13] != 3'b101 |-> !rom_cs && !ram_cs && cpu_rdata == 8'h00);

  p_single_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> !ram_cs);
endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_BANKS(ROM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_rd      (cpu_rd),
  .cpu_wr      (cpu_wr),
  .cpu_rdata   (cpu_rdata),
  .rom_addr    (rom_addr),
  .rom_cs      (rom_cs),
  .ram_cs      (ram_cs),
  .ram_we      (ram_we),
  .en_state    (en_state),
  .mode_state  (mode_state),
  .lo_state    (lo_state),
  .field_state (field_state)
);

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NROM  = 40;
  localparam int NRAM  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [7:0]  rom_rdata;
  logic [14:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_cs;
  logic        ram_we;
  logic [7:0]  ram_rdata;

  logic [7:0] ram_mem [0:32767];
  logic [7:0] shadow  [0:32767];

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [4:0] m_lo;
  logic [1:0] m_hi;
  logic       m_mode;
  logic       m_en;

  always #(CLK_P/2) clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(NROM), .RAM_BANKS(NRAM)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_cs(ram_cs),
    .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_byte(logic [20:0] pa);
    return pa[7:0] ^ {pa[20:14], 1'b1} ^ {2'b00, pa[13:8]};
  endfunction

  assign rom_rdata = rom_byte(rom_addr);
  assign ram_rdata = ram_mem[ram_addr];
  always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

  task automatic cmp(input string tag, input string what, input longint got, input longint exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic probe(input logic [15:0] a, input string tag);
    int bank;
    bit e_rcs, e_mcs;
    int e_ra, e_ma;
    logic [7:0] e_d;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
    e_rcs = 0; e_mcs = 0; e_ra = 0; e_ma = 0; e_d = 8'h00;
    if (a < 16'h4000) begin
      e_rcs = 1; e_ra = int'(a);
    end else if (a < 16'h8000) begin
      bank = m_mode ? int'(m_lo) : int'(m_hi) * 32 + int'(m_lo);
      if (bank < NROM) begin e_rcs = 1; e_ra = bank * 16384 + int'(a) - 16'h4000; end
    end else if (a >= 16'hA000 && a <= 16'hBFFF) begin
      bank = m_mode ? int'(m_hi) : 0;
      if (m_en && bank < NRAM) begin
        e_mcs = 1; e_ma = bank * 8192 + int'(a) - 16'hA000; e_d = shadow[e_ma];
      end
    end
    if (e_rcs) e_d = rom_byte(21'(e_ra));
    cmp(tag, "rom_cs", rom_cs, e_rcs);
    cmp(tag, "ram_cs", ram_cs, e_mcs);
    if (e_rcs) cmp(tag, "rom_addr", rom_addr, e_ra);
    if (e_mcs) cmp(tag, "ram_addr", ram_addr, e_ma);
    cmp(tag, "cpu_rdata", cpu_rdata, e_d);
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d, input string tag);
    int bank;
    bit e_we;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    e_we = 0;
    if (a >= 16'hA000 && a <= 16'hBFFF) begin
      bank = m_mode ? int'(m_hi) : 0;
      if (m_en && bank < NRAM) begin
        e_we = 1; shadow[bank * 8192 + int'(a) - 16'hA000] = d;
      end
    end
    cmp(tag, "ram_we", ram_we, e_we);
    case (a[15:13])
      3'd0: m_en = (d == 8'h0A);
      3'd1: m_lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
      3'd2: m_hi = d[1:0];
      3'd3: m_mode = d[0];
      default: ;
    endcase
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) begin ram_mem[i] = 8'h00; shadow[i] = 8'h00; end
    m_lo = 5'd1; m_hi = 2'd0; m_mode = 1'b0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    probe(16'h4000, "R1");
    probe(16'h5ABC, "R1");
    probe(16'hA000, "R1");

    // R7: fixed bank window
    probe(16'h0000, "R7");
    probe(16'h3FFF, "R7");
    probe(16'h1234, "R7");

    // R3, R4, R5, R8, R10: every low value under every shared field value
    for (int h = 0; h < 4; h++) begin
      poke(16'h4000 | 16'(h << 8), 8'hFC | 8'(h), "R5");
      for (int l = 0; l < 32; l++) begin
        poke(16'h2000 | 16'(l << 7), 8'(l) | 8'hE0, (l == 0) ? "R4" : "R3");
        probe(16'h4000 | 16'((l * 515) & 16'h3FFF),
              ((h * 32 + ((l == 0) ? 1 : l)) >= NROM) ? "R10" : "R8");
        if (h == 1) probe(16'h0100 | 16'(l), "R7");
      end
    end

    // R2: enable key
    poke(16'h0000, 8'h0A, "R2");
    probe(16'hA000, "R2");
    poke(16'h1FFF, 8'h0B, "R2");
    probe(16'hA000, "R2");
    poke(16'h0800, 8'h8A, "R2");
    probe(16'hA001, "R2");
    poke(16'h1000, 8'h0A, "R2");
    probe(16'hA001, "R2");

    // R9: RAM in ROM mode (bank 0)
    for (int k = 0; k < 6; k++) poke(16'hA000 + 16'(k * 16'h0555), 8'h30 + 8'(k), "R9");
    for (int k = 0; k < 6; k++) probe(16'hA000 + 16'(k * 16'h0555), "R9");

    // R6: to RAM mode, field is 3 -> RAM bank out of range
    poke(16'h6000, 8'hFF, "R6");
    probe(16'h4000, "R6");
    probe(16'h7FFF, "R6");
    probe(16'hA000, "R10");
    poke(16'hA020, 8'h77, "R10");
    probe(16'hA020, "R10");

    // R5, R9: RAM banks in RAM mode
    for (int b = 0; b < 3; b++) begin
      poke(16'h5000, 8'hF8 | 8'(b), "R5");
      poke(16'hA000 + 16'(b * 7), 8'hC0 + 8'(b), "R9");
      poke(16'hBFFF, 8'h50 + 8'(b), "R9");
    end
    for (int b = 0; b < 3; b++) begin
      poke(16'h4FFF, 8'(b), "R5");
      probe(16'hA000 + 16'(b * 7), "R9");
      probe(16'hBFFF, "R9");
      probe(16'hA555, "R9");
    end

    // R6: same mode again changes nothing, then back to ROM mode
    poke(16'h6000, 8'h03, "R6");
    probe(16'h4000, "R6");
    probe(16'hBFFF, "R6");
    poke(16'h7FFF, 8'hFE, "R6");
    probe(16'h4000, "R6");
    probe(16'hBFFF, "R6");
    probe(16'hA555, "R6");

    // R9: writes while disabled store nothing
    poke(16'h0000, 8'h00, "R9");
    poke(16'hA555, 8'h5A, "R9");
    probe(16'hA555, "R9");
    poke(16'h0000, 8'h0A, "R9");
    probe(16'hA555, "R9");

    // R11: unmapped windows
    poke(16'h8000, 8'h01, "R11");
    poke(16'h9FFF, 8'h00, "R11");
    poke(16'hC000, 8'h00, "R11");
    poke(16'hE123, 8'h01, "R11");
    poke(16'hFFFF, 8'h0A, "R11");
    probe(16'h8000, "R11");
    probe(16'h9FFF, "R11");
    probe(16'hC000, "R11");
    probe(16'hFFFF, "R11");
    probe(16'h4000, "R11");
    probe(16'hA555, "R11");

    @(negedge clk);
    cpu_rd = 1'b0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule